// File: doc/BRIEF.md
# Supply Monitor Interrupt Controller

This block sits between a set of supply-voltage comparators and the processor's interrupt inputs. It receives one synchronized digital indication per supply condition: battery low, regulator undervoltage, regulator overvoltage, battery in the upper range, and battery in the middle range. Each indication sets a sticky status flag. Software clears a flag by writing 1 to it. If the indication is still present at that point, the flag sets again, so a condition that persists cannot be lost by clearing it.

Two register words are reachable over a simple 32-bit bus. Writes use a one-cycle strobe and read data is combinational. The enable word selects which flags may raise interrupts, and one bit in it chooses which battery range the range interrupt follows. The status word holds the sticky flags and two live copies of the range inputs. The enabled undervoltage and battery-low flags drive a registered nonmaskable interrupt line. The enabled overvoltage and range flags drive a registered maskable interrupt line. Both lines are level-sensitive.

Top module: `supmon_irq_ctrl`

## Requirements
- R1: Out of reset the enable word (offset 0x0) reads 0x0000_0000, the status word (offset 0x4) reads 0x0000_2100, and both `irqOut` and `nmiOut` are 0.
- R2: Only enable bits 0 (battery low), 1 (regulator undervoltage), 2 (regulator overvoltage), 8 (range select) and 10 (range interrupt enable) are writable. Writing all ones reads back 0x0000_0507.
- R3: Status bit 13 follows `inRange1` and status bit 14 follows `inRange2`, each one clock later. Writes have no effect on these bits.
- R4: The sticky flags sit at status bit 0 (battery low), bit 1 (undervoltage), bit 2 (overvoltage), bit 8 (range 1) and bit 9 (range 2). A flag is 1 from the clock after its input is high and stays 1 after the input falls.
- R5: Writing 1 to a flag bit clears the flag when its input is low. Writing 0 leaves the flag unchanged.
- R6: A flag whose input is high in the cycle of a clear write stays 1, and this includes an input that rises in that same cycle.
- R7: When enable bit 10 is set, `irqOut` follows the range-1 flag if bit 8 is 0 and the range-2 flag if bit 8 is 1.
- R8: The overvoltage flag raises `irqOut` only while enable bit 2 is set.
- R9: The undervoltage flag (when enable bit 1 is set) and the battery-low flag (when enable bit 0 is set) raise `nmiOut` and never `irqOut`.
- R10: The interrupt outputs are registered. Each one follows the flags and enables with a one-cycle delay, so it drops one clock after its causing flag is cleared.
- R11: Any address other than 0x0 and 0x4 reads as 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the register being accessed |
| busWrEn | input | 1 | One-cycle write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data |
| inBatLow | input | 1 | Battery below the low threshold |
| inRegUnder | input | 1 | Regulator undervoltage |
| inRegOver | input | 1 | Regulator overvoltage |
| inRange1 | input | 1 | Battery in the upper range |
| inRange2 | input | 1 | Battery in the middle range |
| irqOut | output | 1 | Maskable interrupt, level |
| nmiOut | output | 1 | Nonmaskable interrupt, level |

## Verification
The range interrupt is tested with both values of the select bit while only one of the two range flags is set. This shows that the select bit really chooses between the flags and does not merge them. The bench issues clear writes both while an input is held high and while it is low, and it raises an input in the same cycle as a clear. Together these separate a plain write-one-to-clear from the re-set behaviour and show which side wins when set and clear meet. Each source is first left disabled and then enabled, which shows that masking works and that each source is routed to the correct line. An all-ones write to the enable word and accesses to an unmapped address show which bits and addresses can hold state.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int DATA_W = 32;
  localparam int NFLAG = 5;

  // enable word bit positions
  localparam int EN_BAT = 0;
  localparam int EN_UNDER = 1;
  localparam int EN_OVER = 2;
  localparam int EN_SEL = 8;
  localparam int EN_RANGE = 10;
  localparam logic [DATA_W-1:0] EN_MASK =
      (32'd1 << EN_BAT) | (32'd1 << EN_UNDER) | (32'd1 << EN_OVER) |
      (32'd1 << EN_SEL) | (32'd1 << EN_RANGE);

  // flag index: 0 batLow, 1 under, 2 over, 3 range1, 4 range2
  localparam logic [NFLAG-1:0] FLAG_RST = 5'b01000;
  localparam int LIVE1_POS = 13;
  localparam int LIVE2_POS = 14;

  function automatic int flagPos(int idx);
    case (idx)
      3: flagPos = 8;
      4: flagPos = 9;
      default: flagPos = idx;
    endcase
  endfunction

  typedef struct packed {
    logic enWr;
    logic statWr;
    logic enSel;
    logic statSel;
  } strobes_t;
endpackage

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobes_t          strobes
);
  localparam logic [ADDR_W-1:0] OFS_EN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);

  always_comb begin
    strobes.enSel = (busAddr == OFS_EN);
    strobes.statSel = (busAddr == OFS_STAT);
    strobes.enWr = busWrEn && strobes.enSel;
    strobes.statWr = busWrEn && strobes.statSel;
  end

  // R11: at most one register is written per cycle
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.enWr, strobes.statWr}));
endmodule

// File: rtl/supmon_dp.sv
module supmon_dp
  import supmon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              inBatLow,
  input  logic              inRegUnder,
  input  logic              inRegOver,
  input  logic              inRange1,
  input  logic              inRange2,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              nmiOut
);
  logic [DATA_W-1:0] enQ;
  logic [NFLAG-1:0]  flagQ;
  logic [NFLAG-1:0]  cond;
  logic [1:0]        liveQ;
  logic [DATA_W-1:0] statusVal;
  logic              irqNext;
  logic              nmiNext;

  assign cond = {inRange2, inRange1, inRegOver, inRegUnder, inBatLow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= '0;
    else if (strobes.enWr) enQ <= wrData & EN_MASK;
  end

  // sticky flags: a set beats a clear in the same cycle
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[i] <= FLAG_RST[i];
      else flagQ[i] <= cond[i] | (flagQ[i] & ~(strobes.statWr & wrData[flagPos(i)]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveQ <= 2'b01;
    else liveQ <= {inRange2, inRange1};
  end

  always_comb begin
    statusVal = '0;
    for (int i = 0; i < NFLAG; i++) statusVal[flagPos(i)] = flagQ[i];
    statusVal[LIVE1_POS] = liveQ[0];
    statusVal[LIVE2_POS] = liveQ[1];
  end

  always_comb begin
    irqNext = (enQ[EN_RANGE] & (enQ[EN_SEL] ? flagQ[4] : flagQ[3])) |
              (enQ[EN_OVER] & flagQ[2]);
    nmiNext = (enQ[EN_UNDER] & flagQ[1]) | (enQ[EN_BAT] & flagQ[0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      nmiOut <= 1'b0;
    end else begin
      irqOut <= irqNext;
      nmiOut <= nmiNext;
    end
  end

  always_comb begin
    if (strobes.enSel) rdData = enQ;
    else if (strobes.statSel) rdData = statusVal;
    else rdData = '0;
  end

  p_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusVal[LIVE2_POS] == $past(inRange2)));
  p_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    inRegOver |=> flagQ[2]);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.statWr && wrData[2] && !inRegOver) |=> !flagQ[2]);
  p_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ[EN_OVER] && !enQ[EN_RANGE]) |=> !irqOut);
  p_nmi_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enQ[EN_UNDER] && flagQ[1]) |=> nmiOut);
endmodule

// File: rtl/supmon_irq_ctrl.sv
module supmon_irq_ctrl
  import supmon_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              inBatLow,
  input  logic              inRegUnder,
  input  logic              inRegOver,
  input  logic              inRange1,
  input  logic              inRange2,
  output logic              irqOut,
  output logic              nmiOut
);
  strobes_t strobes;

  supmon_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strobes(strobes)
  );

  supmon_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .inBatLow(inBatLow), .inRegUnder(inRegUnder), .inRegOver(inRegOver),
    .inRange1(inRange1), .inRange2(inRange2),
    .rdData(busRdData), .irqOut(irqOut), .nmiOut(nmiOut)
  );
endmodule

// File: tb/supmon_irq_ctrl_tb_top.sv
module supmon_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic inBatLow = 1'b0, inRegUnder = 1'b0, inRegOver = 1'b0;
  logic inRange1 = 1'b1, inRange2 = 1'b0;
  logic irqOut, nmiOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 read word, 1 irqOut, 2 nmiOut
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t expQ[$];

  always #5 clk = ~clk;

  supmon_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .inBatLow(inBatLow), .inRegUnder(inRegUnder), .inRegOver(inRegOver),
    .inRange1(inRange1), .inRange2(inRange2), .irqOut(irqOut), .nmiOut(nmiOut)
  );

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.kind)
          0: act = busRdData;
          1: act = {31'd0, irqOut};
          default: act = {31'd0, nmiOut};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic expReg(input logic [3:0] a, input logic [31:0] e, input string r);
    item_t it;
    busAddr = a;
    it.kind = 0; it.exp = e; it.req = r;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic expPin(input int k, input logic e, input string r);
    item_t it;
    it.kind = k; it.exp = {31'd0, e}; it.req = r;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expReg(4'h4, 32'h0000_2100, "R1 status");
    expReg(4'h0, 32'h0, "R1 enable");
    expPin(1, 1'b0, "R1 irq");
    expPin(2, 1'b0, "R1 nmi");
    // R2 writable mask
    wr(4'h0, 32'hFFFF_FFFF);
    expReg(4'h0, 32'h0000_0507, "R2 mask");
    expPin(1, 1'b0, "R7 sel=1 range2 flag clear");
    wr(4'h0, 32'h0000_0400); tick();
    expPin(1, 1'b1, "R7 sel=0 follows range1");
    wr(4'h0, 32'h0); tick();
    expPin(1, 1'b0, "R10 irq follows enable");
    // R6 clear while range1 held
    wr(4'h4, 32'h0000_0100);
    expReg(4'h4, 32'h0000_2100, "R6 persist re-set");
    inRange1 = 1'b0; tick();
    expReg(4'h4, 32'h0000_0100, "R4 sticky range1 R3 live drop");
    wr(4'h4, 32'h0);
    expReg(4'h4, 32'h0000_0100, "R5 write zero no effect");
    wr(4'h4, 32'hFFFF_FFFF);
    expReg(4'h4, 32'h0, "R5 clear range1");
    // range2
    inRange2 = 1'b1; tick();
    expReg(4'h4, 32'h0000_4200, "R3 R4 range2 live and flag");
    inRange2 = 1'b0; tick();
    expReg(4'h4, 32'h0000_0200, "R4 range2 sticky");
    wr(4'h0, 32'h0000_0500); tick();
    expPin(1, 1'b1, "R7 sel=1 follows range2");
    wr(4'h0, 32'h0000_0400); tick();
    expPin(1, 1'b0, "R7 sel=0 ignores range2");
    wr(4'h0, 32'h0000_0500); tick();
    wr(4'h4, 32'h0000_0200);
    expPin(1, 1'b1, "R10 irq held one cycle");
    expPin(1, 1'b0, "R10 irq drops after clear");
    // R8 overvoltage gating
    wr(4'h0, 32'h0);
    inRegOver = 1'b1; tick(); tick();
    expPin(1, 1'b0, "R8 masked overvoltage");
    wr(4'h0, 32'h0000_0004); tick();
    expPin(1, 1'b1, "R8 enabled overvoltage");
    expPin(2, 1'b0, "R9 overvoltage not on nmi");
    inRegOver = 1'b0;
    wr(4'h4, 32'h0000_0004); tick();
    expPin(1, 1'b0, "R10 overvoltage cleared");
    // R9 undervoltage on nmi
    inRegUnder = 1'b1;
    wr(4'h0, 32'h0000_0002); tick();
    expPin(2, 1'b1, "R9 undervoltage nmi");
    expPin(1, 1'b0, "R9 undervoltage not on irq");
    wr(4'h4, 32'h0000_0002);
    expReg(4'h4, 32'h0000_0002, "R6 undervoltage persists");
    inRegUnder = 1'b0;
    wr(4'h4, 32'h0000_0002);
    expReg(4'h4, 32'h0, "R5 undervoltage cleared");
    expPin(2, 1'b0, "R10 nmi drops");
    // battery low
    inBatLow = 1'b1;
    wr(4'h0, 32'h0000_0001); tick();
    expPin(2, 1'b1, "R9 battery low nmi");
    inBatLow = 1'b0;
    wr(4'h4, 32'h0000_0001); tick();
    expPin(2, 1'b0, "R9 battery low cleared");
    // R6 set rising with clear in same cycle
    inRegOver = 1'b1;
    wr(4'h4, 32'h0000_0004);
    expReg(4'h4, 32'h0000_0004, "R6 set wins over clear");
    inRegOver = 1'b0;
    // R11 unmapped
    wr(4'h8, 32'hFFFF_FFFF);
    expReg(4'h8, 32'h0, "R11 unmapped reads zero");
    expReg(4'h0, 32'h0000_0001, "R11 enable untouched");
    expReg(4'h4, 32'h0000_0004, "R11 status untouched");
    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule